// File: doc/BRIEF.md
# Bus Talker Handshake Engine

This block is the sending half of the three-wire byte handshake used on an IEEE-488 instrument bus. A local producer offers bytes on a valid/ready interface. The block places each byte on eight active-low data lines and waits for the required settling time. It then drives the data-valid strobe and watches the two wired-OR listener lines, not-ready-for-data and not-data-accepted. On the final byte of a message it can also pull the end-of-message line.

Every bus line uses inverted logic: a logical 1 or an asserted state is a low level. The block therefore inverts the byte before driving it, and it reads the listener lines as raw levels, high meaning released. Both listener lines pass through a multi-stage synchronizer before the controller uses them. If both listener lines are released when a byte is offered, nobody is listening: the block swallows the byte and raises a sticky error. If the bus makes no progress within a programmable number of cycles, the block drops the strobe, raises a second sticky error and becomes ready again. The block drives no transceiver direction pin itself. It reports a single drive-enable flag for the bus-side logic to use.

Top module: `gpib_talker_hs`

## Requirements
- R1: Out of reset the block is ready (`tx_ready`=1), `bus_dav_n`, `bus_eoi_n` and all of `bus_dio_n` are high, `talk_oe` is 0 and both error flags are 0. The same released levels hold whenever `talk_oe` is 0.
- R2: A byte accepted when `tx_valid` and `tx_ready` are both high is driven as its bitwise inverse on `bus_dio_n` from the next clock onward, for as long as the strobe is low.
- R3: `bus_dav_n` never goes low while the synchronized `bus_nrfd_n` is low. Once `bus_nrfd_n` rises, the strobe falls on the third clock edge, provided settling is complete.
- R4: With `bus_nrfd_n` already high, `bus_dav_n` falls exactly SETTLE_CYC clock cycles after the byte is accepted. The data therefore stays stable for that long before the strobe.
- R5: If the synchronized `bus_nrfd_n` and `bus_ndac_n` are both high when a byte is offered, the byte is consumed and never strobed, `talk_oe` stays 0, and `err_nolisten` rises and stays high until reset.
- R6: While the strobe is low, the block releases `bus_dav_n` on the third clock edge after `bus_ndac_n` rises, and not before.
- R7: After releasing the strobe, the block keeps `tx_ready` low until the synchronized `bus_ndac_n` is low again. It returns to ready on the third edge after that fall.
- R8: `bus_eoi_n` is low alongside the data of a byte that was offered with `tx_last`=1 while `end_mark_en`=1. It stays high for every other byte.
- R9: If the strobe cannot be raised, or the acceptance is not seen, within TIMEOUT_CYC cycles of entering that wait, the block releases all lines, returns to ready and sets `err_timeout` until reset. When the wait is for `bus_ndac_n`, the strobe stays low for exactly TIMEOUT_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | DATA_W | Byte offered by the producer (positive logic) |
| tx_last | input | 1 | Offered byte ends the message |
| tx_valid | input | 1 | Offered byte is valid |
| tx_ready | output | 1 | Block can take a byte this cycle |
| end_mark_en | input | 1 | Allow the end-of-message line on last bytes |
| bus_nrfd_n | input | 1 | Raw not-ready-for-data level, low = asserted |
| bus_ndac_n | input | 1 | Raw not-data-accepted level, low = asserted |
| bus_dio_n | output | DATA_W | Data lines, active-low, all high when released |
| bus_dav_n | output | 1 | Data-valid strobe, low = asserted |
| bus_eoi_n | output | 1 | End-of-message line, low = asserted |
| talk_oe | output | 1 | Block is presenting a byte on the bus |
| err_nolisten | output | 1 | Sticky: a byte was offered with no listener present |
| err_timeout | output | 1 | Sticky: a handshake wait expired |

## Verification
The bench counts the cycles from acceptance to the strobe and from strobe to release. A design that strobed early, skipped settling or hid the timeout off by one would miss those exact counts. It holds the not-ready line low well past the settling time and checks that the strobe waits for its release. It leaves the acceptance line released after the strobe drops, which exposes a design that would count one acceptance twice by going ready too early. It also offers a byte to an empty bus and expects the byte to be swallowed with the error raised, and it checks that the error flags survive later good transfers.

// File: rtl/gth_pkg.sv
package gth_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_SETTLE = 2'd1,
      ST_STROBE = 2'd2,
      ST_REARM  = 2'd3
   } gth_state_e;
endpackage

// File: rtl/gth_sync.sv
module gth_sync #(
   parameter int          W       = 2,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gth_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gth_sync: W must be at least 1");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_in};
      end
   end

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/gth_timer.sv
module gth_timer #(
   parameter int SETTLE_CYC  = 192,
   parameter int TIMEOUT_CYC = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic settled,
   output logic expired
);
   localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] EXPIRE_LAST = CNT_W'(TIMEOUT_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || restart) begin
         cnt_q <= '0;
      end else if (!expired) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign settled = (cnt_q >= SETTLE_LAST);
   assign expired = (cnt_q == EXPIRE_LAST);

   // R9: the wait counter never runs past its expiry value
   p_cnt_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= EXPIRE_LAST);
endmodule

// File: rtl/gpib_talker_hs.sv
module gpib_talker_hs
   import gth_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SETTLE_CYC  = 192,
   parameter int TIMEOUT_CYC = 125000,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_EOI     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_last,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic              end_mark_en,
   input  logic              bus_nrfd_n,
   input  logic              bus_ndac_n,
   output logic [DATA_W-1:0] bus_dio_n,
   output logic              bus_dav_n,
   output logic              bus_eoi_n,
   output logic              talk_oe,
   output logic              err_nolisten,
   output logic              err_timeout
);
   if (DATA_W < 1) begin : g_bad_dw
      $error("gpib_talker_hs: DATA_W must be positive");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("gpib_talker_hs: SETTLE_CYC must be at least 1");
   end
   if (TIMEOUT_CYC <= SETTLE_CYC) begin : g_bad_timeout
      $error("gpib_talker_hs: TIMEOUT_CYC must exceed SETTLE_CYC");
   end

   // listener lines: bit 0 = not-ready, bit 1 = not-accepted (raw levels)
   logic [1:0] lines_s;
   logic       nrfd_ok;   // every listener ready (line high)
   logic       ndac_rel;  // every listener accepted (line high)

   gth_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({bus_ndac_n, bus_nrfd_n}),
      .q_out (lines_s)
   );
   assign nrfd_ok  = lines_s[0];
   assign ndac_rel = lines_s[1];

   gth_state_e        state_q, state_d;
   logic              settled, expired, restart;
   logic              to_hit;
   logic              accept, no_listener;
   logic [DATA_W-1:0] data_q;
   logic              last_q;
   logic              dav_q, drive_q, eoi_q;
   logic              err_nl_q, err_to_q;

   gth_timer #(.SETTLE_CYC(SETTLE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .settled (settled),
      .expired (expired)
   );

   assign tx_ready    = (state_q == ST_IDLE);
   assign accept      = tx_valid && tx_ready;
   assign no_listener = nrfd_ok && ndac_rel;
   assign restart     = (state_q == ST_IDLE) || (state_d != state_q);

   always_comb begin
      state_d = state_q;
      to_hit  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (tx_valid && !no_listener) state_d = ST_SETTLE;
         end
         ST_SETTLE: begin
            if (settled && nrfd_ok) begin
               state_d = ST_STROBE;
            end else if (expired) begin
               state_d = ST_IDLE;
               to_hit  = 1'b1;
            end
         end
         ST_STROBE: begin
            if (ndac_rel) begin
               state_d = ST_REARM;
            end else if (expired) begin
               state_d = ST_IDLE;
               to_hit  = 1'b1;
            end
         end
         ST_REARM: begin
            if (!ndac_rel) begin
               state_d = ST_IDLE;
            end else if (expired) begin
               state_d = ST_IDLE;
               to_hit  = 1'b1;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         data_q   <= '0;
         last_q   <= 1'b0;
         dav_q    <= 1'b0;
         drive_q  <= 1'b0;
         err_nl_q <= 1'b0;
         err_to_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            data_q <= tx_data;
            last_q <= tx_last && end_mark_en;
         end
         dav_q    <= (state_d == ST_STROBE);
         drive_q  <= (state_d != ST_IDLE);
         err_nl_q <= err_nl_q || (accept && no_listener);
         err_to_q <= err_to_q || to_hit;
      end
   end

   // end-of-message line: present only in the variant that has one
   if (HAS_EOI) begin : g_eoi
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            eoi_q <= 1'b0;
         end else begin
            eoi_q <= ((state_d == ST_SETTLE) || (state_d == ST_STROBE)) &&
                     (accept ? (tx_last && end_mark_en) : last_q);
         end
      end
   end else begin : g_no_eoi
      assign eoi_q = 1'b0;
   end

   assign bus_dav_n    = ~dav_q;
   assign bus_dio_n    = drive_q ? ~data_q : '1;
   assign bus_eoi_n    = ~eoi_q;
   assign talk_oe      = drive_q;
   assign err_nolisten = err_nl_q;
   assign err_timeout  = err_to_q;

   // R1: lines stay released whenever the block is not presenting a byte
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !talk_oe |-> (bus_dav_n && bus_eoi_n && (bus_dio_n == '1)));
   // R3: the strobe only falls after the synchronized ready level was seen
   p_dav_needs_nrfd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_dav_n) |-> $past(nrfd_ok));
   // R4: the strobe only falls once the settling window has run out
   p_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_dav_n) |-> $past(settled));
   // R5: a byte offered to an empty bus sets the error and is never strobed
   p_nolisten_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && no_listener) |=> (err_nolisten && bus_dav_n && !talk_oe));
   // R6: the strobe is released only on acceptance or on a timeout
   p_dav_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_dav_n) |-> ($past(ndac_rel) || err_timeout));
   // R7: readiness returns only after acceptance is re-armed or on timeout
   p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready) |-> (!$past(ndac_rel) || err_timeout));
   // R8: the end mark appears only while a byte is on the bus
   p_eoi_with_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_eoi_n |-> talk_oe);
   // R9: the timeout flag is sticky
   p_timeout_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |=> err_timeout);
endmodule

// File: tb/gpib_talker_hs_bench.sv
module gpib_talker_hs_bench;
   localparam int SET = 192;
   localparam int TO  = 400;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_last = 1'b0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic       end_mark_en = 1'b0;
   logic       nrfd_n = 1'b1;
   logic       ndac_n = 1'b0;
   logic [7:0] dio_n;
   logic       dav_n, eoi_n, talk_oe, err_nl, err_to;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   gpib_talker_hs #(.SETTLE_CYC(SET), .TIMEOUT_CYC(TO)) u_gpib_talker_hs (
      .clk          (clk),
      .rst_n        (rst_n),
      .tx_data      (tx_data),
      .tx_last      (tx_last),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .end_mark_en  (end_mark_en),
      .bus_nrfd_n   (nrfd_n),
      .bus_ndac_n   (ndac_n),
      .bus_dio_n    (dio_n),
      .bus_dav_n    (dav_n),
      .bus_eoi_n    (eoi_n),
      .talk_oe      (talk_oe),
      .err_nolisten (err_nl),
      .err_timeout  (err_to)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      tx_valid = 1'b0;
      tx_last = 1'b0;
      end_mark_en = 1'b0;
      nrfd_n = 1'b1;
      ndac_n = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   // offer one byte; returns at the negedge after the accepting edge
   task automatic send_byte(input logic [7:0] d, input logic last);
      for (int i = 0; i < 1000 && !tx_ready; i++) @(negedge clk);
      tx_data  = d;
      tx_last  = last;
      tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   // count negedges with the strobe still high, starting at the current one
   task automatic count_until_dav(output int n);
      n = 0;
      while (dav_n && n < 2000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // listener side: accept a strobed byte and re-arm, no checks
   task automatic listener_finish();
      nrfd_n = 1'b0;
      repeat (3) @(negedge clk);
      ndac_n = 1'b1;
      for (int i = 0; i < 50 && !dav_n; i++) @(negedge clk);
      ndac_n = 1'b0;
      repeat (4) @(negedge clk);
      nrfd_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk(tx_ready == 1'b1, "R1", "ready after reset", tx_ready, 1);
      chk(dav_n && eoi_n, "R1", "dav/eoi released", {dav_n, eoi_n}, 3);
      chk(dio_n == 8'hFF, "R1", "data released", dio_n, 8'hFF);
      chk(!talk_oe && !err_nl && !err_to, "R1", "oe/errors clear",
          {talk_oe, err_nl, err_to}, 0);
   endtask

   task automatic t_transfer(input logic [7:0] d, input logic last, input logic en);
      int n;
      end_mark_en = en;
      send_byte(d, last);
      chk(dio_n == ~d, "R2", "data inverted at accept", dio_n, ~d);
      chk(talk_oe, "R2", "drive enable", talk_oe, 1);
      count_until_dav(n);
      chk(n == SET, "R4", "settle cycles before strobe", n, SET);
      chk(dio_n == ~d, "R2", "data under strobe", dio_n, ~d);
      chk(eoi_n == !(last && en), "R8", "end mark level", eoi_n, !(last && en));
      nrfd_n = 1'b0;
      repeat (4) @(negedge clk);
      ndac_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(dav_n == 1'b0, "R6", "strobe held 2 edges after accept", dav_n, 0);
      @(negedge clk);
      chk(dav_n == 1'b1, "R6", "strobe released 3rd edge", dav_n, 1);
      repeat (20) @(negedge clk);
      chk(tx_ready == 1'b0, "R7", "not ready while accept released", tx_ready, 0);
      ndac_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(tx_ready == 1'b0, "R7", "still busy 2 edges after re-arm", tx_ready, 0);
      @(negedge clk);
      chk(tx_ready == 1'b1, "R7", "ready 3rd edge after re-arm", tx_ready, 1);
      chk(!talk_oe && dio_n == 8'hFF && eoi_n, "R1", "released after byte",
          {talk_oe, dio_n, eoi_n}, 9'h1FF);
      nrfd_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_nrfd_hold();
      int held;
      do_reset();
      nrfd_n = 1'b0;
      repeat (4) @(negedge clk);
      send_byte(8'h3C, 1'b0);
      held = 0;
      for (int i = 0; i < 300; i++) begin
         if (dav_n) held++;
         @(negedge clk);
      end
      chk(held == 300, "R3", "strobe waits for ready", held, 300);
      nrfd_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(dav_n == 1'b1, "R3", "strobe high 2 edges after ready", dav_n, 1);
      @(negedge clk);
      chk(dav_n == 1'b0, "R3", "strobe low 3rd edge after ready", dav_n, 0);
      chk(dio_n == 8'hC3, "R2", "held byte on bus", dio_n, 8'hC3);
      listener_finish();
   endtask

   task automatic t_nolisten();
      int quiet;
      do_reset();
      nrfd_n = 1'b1;
      ndac_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(tx_ready == 1'b1, "R5", "ready with empty bus", tx_ready, 1);
      send_byte(8'h5A, 1'b0);
      chk(err_nl == 1'b1, "R5", "no-listener flag", err_nl, 1);
      quiet = 0;
      for (int i = 0; i < 300; i++) begin
         if (dav_n && !talk_oe) quiet++;
         @(negedge clk);
      end
      chk(quiet == 300, "R5", "byte never strobed", quiet, 300);
      chk(tx_ready == 1'b1, "R5", "byte consumed", tx_ready, 1);
      ndac_n = 1'b0;
      repeat (4) @(negedge clk);
      t_transfer(8'h81, 1'b0, 1'b0);
      chk(err_nl == 1'b1, "R5", "flag sticky after good byte", err_nl, 1);
   endtask

   task automatic t_timeout_ready();
      do_reset();
      nrfd_n = 1'b0;
      repeat (4) @(negedge clk);
      send_byte(8'h77, 1'b0);
      repeat (TO - 1) @(negedge clk);
      chk(err_to == 1'b0, "R9", "no timeout one cycle early", err_to, 0);
      @(negedge clk);
      chk(err_to == 1'b1, "R9", "timeout flag on time", err_to, 1);
      chk(tx_ready && dav_n && !talk_oe, "R9", "back to ready, released",
          {tx_ready, dav_n, talk_oe}, 3'b110);
   endtask

   task automatic t_timeout_accept();
      int n;
      do_reset();
      send_byte(8'h12, 1'b0);
      count_until_dav(n);
      nrfd_n = 1'b0;
      n = 0;
      while (!dav_n && n < 2000) begin
         n++;
         @(negedge clk);
      end
      chk(n == TO, "R9", "strobe length before timeout", n, TO);
      chk(err_to == 1'b1, "R9", "timeout flag set", err_to, 1);
      chk(tx_ready && !talk_oe, "R9", "ready after timeout", {tx_ready, talk_oe}, 2'b10);
      nrfd_n = 1'b1;
      repeat (4) @(negedge clk);
      t_transfer(8'hE7, 1'b1, 1'b1);
      chk(err_to == 1'b1, "R9", "timeout flag sticky", err_to, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_transfer(8'hA5, 1'b0, 1'b0);
      t_transfer(8'h01, 1'b1, 1'b1);   // R8 end mark on last byte
      t_transfer(8'hFE, 1'b1, 1'b0);   // R8 mark suppressed when disabled
      t_transfer(8'h40, 1'b0, 1'b1);   // R8 mark absent on non-last byte
      t_nrfd_hold();
      t_nolisten();
      t_timeout_ready();
      t_timeout_accept();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule